// File: doc/BRIEF.md
# Selectable Periodic Time-Base Generator

This block makes two periodic timeout pulses from a single internal tick stream, here called the base tick. The base tick comes from one of three places. The first is a fixed divide-by-four of the system clock. The other two are tick-enable inputs that stand in for a watchdog oscillator and a real-time oscillator. All three sources run in the one synchronous clock domain.

A free-running prescaler counts base ticks. Two power-of-two taps on the prescaler produce the outputs:

- **Slow timeout.** A static configuration input picks a period of 2^12 to 2^15 ticks.
- **Alarm timeout.** A 3-bit run-time field picks a period of 2^8 to 2^15 ticks.

Each output is a single-cycle pulse meant to set an interrupt request flag next to the block. Both taps share one prescaler, so changing either selection never restarts the count.

Top module: `tbase_gen`

## Requirements
- R1: With `src_sel` = 0, `fs_tick` is high in exactly one of every four clock cycles. The first such cycle is the fourth cycle after reset is released.
- R2: With `src_sel` = 1, `fs_tick` follows `wdt_tick` in the same cycle. With `src_sel` = 2, it follows `rtc_tick` in the same cycle. With `src_sel` = 3, `fs_tick` stays low.
- R3: `tb_pulse` is high in a cycle exactly when `fs_tick` is high and the prescaler holds 2^(12+`tb_cfg`)-1 modulo 2^(12+`tb_cfg`). The pulse therefore recurs every 2^(12+`tb_cfg`) base ticks.
- R4: `rt_pulse` is high in a cycle exactly when `fs_tick` is high and the prescaler holds 2^(8+`rt_sel`)-1 modulo 2^(8+`rt_sel`). The pulse therefore recurs every 2^(8+`rt_sel`) base ticks.
- R5: Each timeout pulse lasts one cycle and appears only in a cycle where `fs_tick` is high.
- R6: A change of `rt_sel` takes effect in the same cycle and leaves the prescaler count unchanged.
- R7: While `rst` is high, all outputs are low. After reset the prescaler restarts from zero, so the first pulse on each output comes only after one full period of base ticks.
- R8: The prescaler advances by one on each base tick, wraps from 2^15-1 to 0, and holds its value in cycles without a base tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Base tick source: 0 system/4, 1 watchdog tick, 2 real-time tick, 3 none |
| wdt_tick | input | 1 | Watchdog oscillator tick enable |
| rtc_tick | input | 1 | Real-time oscillator tick enable |
| tb_cfg | input | 2 | Static slow-timeout select, period 2^(12+value) ticks |
| rt_sel | input | 3 | Alarm-timeout select, period 2^(8+value) ticks |
| fs_tick | output | 1 | Selected base tick |
| tb_pulse | output | 1 | Slow timeout pulse |
| rt_pulse | output | 1 | Alarm timeout pulse |

## Verification
The three outputs are combinational from the registered divider, the registered prescaler and the present inputs. A tick-enable input or a select change therefore shows at the outputs in the same cycle. Register state moves one clock edge later.

The bench drives inputs on the falling edge and waits a short delay before comparing the outputs with a behavioural integer model. It then advances the model the way the registers will move at the next rising edge.

The source is switched to a constant-high watchdog tick to reach the 2^15 periods quickly. A random real-time tick stream covers the case of gaps between ticks.

// File: rtl/tbase_gen.sv
module tbase_gen #(
  parameter int CNT_W = 15,
  parameter int TB_LO = 12,
  parameter int RT_LO = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       wdt_tick,
  input  logic       rtc_tick,
  input  logic [1:0] tb_cfg,
  input  logic [2:0] rt_sel,
  output logic       fs_tick,
  output logic       tb_pulse,
  output logic       rt_pulse
);

  localparam int TB_SH = CNT_W - TB_LO;
  localparam int RT_SH = CNT_W - RT_LO;
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [1:0]       div_q;
  logic [CNT_W-1:0] pre_q;
  logic             src_tick;
  logic [CNT_W-1:0] tb_mask;
  logic [CNT_W-1:0] rt_mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 2'd1;
  end

  always_comb begin
    case (src_sel)
      2'd0:    src_tick = (div_q == 2'd3);
      2'd1:    src_tick = wdt_tick;
      2'd2:    src_tick = rtc_tick;
      default: src_tick = 1'b0;
    endcase
  end

  assign fs_tick = src_tick & ~rst;

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (fs_tick) pre_q <= pre_q + 1'b1;
  end

  assign tb_mask  = ONES >> (TB_SH - int'(tb_cfg));
  assign rt_mask  = ONES >> (RT_SH - int'(rt_sel));
  assign tb_pulse = fs_tick && ((pre_q & tb_mask) == tb_mask);
  assign rt_pulse = fs_tick && ((pre_q & rt_mask) == rt_mask);

endmodule

// File: rtl/tbase_gen_chk.sv
module tbase_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] src_sel,
  input logic [1:0] tb_cfg,
  input logic [2:0] rt_sel,
  input logic       fs_tick,
  input logic       tb_pulse,
  input logic       rt_pulse
);

  a_r5_tb_with_tick: assert property (@(posedge clk) disable iff (rst)
    tb_pulse |-> fs_tick);

  a_r5_rt_with_tick: assert property (@(posedge clk) disable iff (rst)
    rt_pulse |-> fs_tick);

  a_r7_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!fs_tick && !tb_pulse && !rt_pulse));

  a_r1_div_spacing: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd0 && fs_tick) |=> !fs_tick);

  a_r3_tb_implies_rt: assert property (@(posedge clk) disable iff (rst)
    (tb_pulse && ({1'b0, rt_sel} <= {2'b0, tb_cfg} + 4'd4)) |-> rt_pulse);

  a_r4_longest_match: assert property (@(posedge clk) disable iff (rst)
    (tb_cfg == 2'd3 && rt_sel == 3'd7) |-> (tb_pulse == rt_pulse));

endmodule

bind tbase_gen tbase_gen_chk u_chk (
  .clk(clk), .rst(rst), .src_sel(src_sel), .tb_cfg(tb_cfg), .rt_sel(rt_sel),
  .fs_tick(fs_tick), .tb_pulse(tb_pulse), .rt_pulse(rt_pulse)
);

// File: tb/tbase_gen_bench.sv
module tbase_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel = 2'd0;
  logic       wdt_tick = 1'b0;
  logic       rtc_tick = 1'b0;
  logic [1:0] tb_cfg = 2'd0;
  logic [2:0] rt_sel = 3'd0;
  logic       fs_tick, tb_pulse, rt_pulse;

  int checks = 0;
  int errors = 0;
  int m_div = 0;
  int m_pre = 0;
  int since_rst = 0;
  int tb_seen = 0;
  int rt_seen = 0;

  tbase_gen u_tbase_gen (
    .clk(clk), .rst(rst), .src_sel(src_sel), .wdt_tick(wdt_tick),
    .rtc_tick(rtc_tick), .tb_cfg(tb_cfg), .rt_sel(rt_sel),
    .fs_tick(fs_tick), .tb_pulse(tb_pulse), .rt_pulse(rt_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic step(input string tick_tag);
    logic e_fs, e_tb, e_rt;
    int tp, rp;
    #1;
    if (rst) e_fs = 1'b0;
    else case (src_sel)
      2'd0: e_fs = (m_div == 3);
      2'd1: e_fs = wdt_tick;
      2'd2: e_fs = rtc_tick;
      default: e_fs = 1'b0;
    endcase
    tp = 1 << (12 + int'(tb_cfg));
    rp = 1 << (8 + int'(rt_sel));
    e_tb = e_fs && ((m_pre % tp) == tp - 1);
    e_rt = e_fs && ((m_pre % rp) == rp - 1);
    check(tick_tag, fs_tick, e_fs);
    check("R3 slow timeout", tb_pulse, e_tb);
    check("R4/R6 alarm timeout", rt_pulse, e_rt);
    if (tb_pulse) tb_seen++;
    if (rt_pulse) rt_seen++;
    if (rst) begin
      m_div = 0; m_pre = 0; since_rst = 0;
    end else begin
      m_div = (m_div + 1) % 4;
      if (e_fs) m_pre = (m_pre + 1) % 32768;
      since_rst++;
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    run(3, "R7 reset quiet");
    @(negedge clk); rst = 1'b0; step("R1 first tick");
    // R1 + R3 + R7: system/4 source, first full slow period at 4096 ticks
    tb_seen = 0; rt_seen = 0;
    run(4 * 4096 + 8, "R1 system/4");
    check("R7 one slow pulse after first period", tb_seen == 1, 1'b1);
    check("R4 alarm pulses at 256 ticks", rt_seen == 16, 1'b1);
    // R2 watchdog source, constant high, long taps and wrap (R8)
    @(negedge clk); src_sel = 2'd1; wdt_tick = 1'b1; tb_cfg = 2'd3; rt_sel = 3'd7;
    step("R2 watchdog");
    tb_seen = 0;
    run(40000, "R2/R8 watchdog");
    check("R8 wrap gives slow pulse", tb_seen >= 1, 1'b1);
    // R6: change alarm select mid-count
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); rt_sel = 3'(s); tb_cfg = 2'(s % 4);
      step("R6 select change");
      run(1500, "R6 alarm select");
    end
    // R2 real-time source with gaps
    @(negedge clk); src_sel = 2'd2; wdt_tick = 1'b0; rt_sel = 3'd0;
    step("R2 rtc");
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      rtc_tick = ($urandom_range(0, 2) == 0);
      wdt_tick = ~rtc_tick;
      step("R2 rtc tick");
    end
    // R2/R8: no source, prescaler holds
    @(negedge clk); src_sel = 2'd3; wdt_tick = 1'b1; rtc_tick = 1'b1;
    step("R2 none");
    tb_seen = 0; rt_seen = 0;
    run(600, "R2/R8 no source");
    check("R8 no pulses without ticks", (tb_seen + rt_seen) == 0, 1'b1);
    // R7: mid-run reset restarts count
    @(negedge clk); rst = 1'b1; src_sel = 2'd1; rt_sel = 3'd0; tb_cfg = 2'd0;
    step("R7 reset");
    @(negedge clk); rst = 1'b0; step("R7 release");
    tb_seen = 0; rt_seen = 0;
    run(254, "R7 restart");
    check("R7 no alarm before full period", rt_seen == 0, 1'b1);
    run(4, "R7 restart");
    check("R7 alarm after full period", rt_seen == 1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule